// File: doc/BRIEF.md
# Dual-Mode Serial Word Output Port

This block sits after a bit slicer that recovers 1200-baud frequency-shift-keyed data. It frames the incoming bit stream into bytes (a low start bit, eight data bits with the least significant bit first, then a high stop bit) and hands the result to a host microcontroller over three wires: a data line, a bit clock and an active-low ready strobe. The upstream slicer delivers one `bit_vld` strobe per recovered bit. Bit timing inside the block comes from `half_tick`, a clock-enable that pulses twice per bit period. There is no second clock domain.

A static mode input picks the host protocol. With `mode_sel` low, the block drives the bit clock. Each data bit goes onto `data_out` as soon as it is recovered, together with a clock pulse that lasts one half-bit interval. After the eighth pulse, `dr_n` goes low for one half-bit interval so that the host can latch its shift register. With `mode_sel` high, the bit clock is an input from the host. Each complete byte with a good stop bit is buffered, and `dr_n` goes low to announce it. The host then clocks the byte out. If a byte arrives before the previous one has been fully read, it replaces the old one and a sticky overrun flag is set. `fsk_en` gates the framer, and `pwdn` clears the whole block to idle.

Framer states: F_HUNT (waiting for a low start bit) goes to F_BITS on a start bit. F_BITS goes to F_STOP after the eighth data bit. F_STOP returns to F_HUNT on the next bit. Host-clock stream states: S_IDLE goes to S_CLKHI on a data bit. S_CLKHI returns to S_IDLE on a half tick, or goes to S_MARK on a half tick if the bit was the last of the word. A new data bit restarts S_CLKHI. S_MARK returns to S_IDLE on a half tick, or goes to S_CLKHI on a data bit. Buffer states: B_EMPTY goes to B_READY when a byte is loaded. B_READY goes to B_SHIFT on the first host rising edge. B_SHIFT goes to B_EMPTY on the last rising edge. A new byte sends any state to B_READY.

Top module: `serial_word_port`

## Requirements
- R1: After reset, `dr_n`=1, `dclk_out`=0, `data_out`=1 (idle level) and `overrun`=0. `dclk_oe` is 1 exactly when `mode_sel`=0 and `pwdn`=0.
- R2: With `mode_sel`=0, each data bit appears on `data_out` with `dclk_out`=1 two clock edges after its `bit_vld` is sampled. The pulse ends on the next `half_tick`. Start and stop bits produce no pulse.
- R3: With `mode_sel`=0, `dr_n` goes low in the same cycle that the eighth data pulse ends. It returns high on the next `half_tick`. It stays high after the first seven pulses.
- R4: A frame is a 0 start bit, then eight data bits with the least significant bit first, then a stop bit. A byte whose stop bit is 0 is discarded: with `mode_sel`=1, `dr_n` stays high.
- R5: With `mode_sel`=1, `dr_n` goes low when a byte with a good stop bit completes, and `data_out` then shows data bit 0.
- R6: With `mode_sel`=1, each rising edge on `dclk_in` advances `data_out` to the next bit, and the first rising edge returns `dr_n` high. After eight rising edges the buffer is empty and `data_out` is 1.
- R7: With `mode_sel`=1, a byte that completes before the previous byte has had eight rising edges replaces that byte and sets `overrun`. `overrun` stays set until reset, `pwdn`, or a change to `mode_sel`=0.
- R8: While `fsk_en`=0, incoming bits are ignored: no data pulse, no `dr_n` strobe, and the framer returns to hunting for a start bit.
- R9: While `pwdn`=1, `dclk_oe` is 0. From the next clock edge on, `dr_n`=1, `dclk_out`=0, `data_out`=1 and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwdn | input | 1 | Active-high power-down, clears block |
| fsk_en | input | 1 | Must be high for bits to be framed |
| mode_sel | input | 1 | 0: block drives bit clock; 1: host drives it |
| half_tick | input | 1 | Clock-enable at twice the bit rate |
| bit_vld | input | 1 | One-cycle strobe per recovered bit |
| bit_in | input | 1 | Recovered bit value |
| dclk_in | input | 1 | Host bit clock (asynchronous), used in mode 1 |
| dclk_out | output | 1 | Block-driven bit clock, used in mode 0 |
| dclk_oe | output | 1 | Output enable for the bit-clock pad |
| data_out | output | 1 | Serial data line |
| dr_n | output | 1 | Active-low data-ready strobe |
| overrun | output | 1 | Sticky buffer overrun flag |

## Verification
A framer whose bit counter has drifted shows up at the ports within one frame. With `mode_sel`=0 the `dr_n` strobe lands after the wrong pulse. With `mode_sel`=1 the byte that is read back is rotated or shows up with no strobe at all. A buffer whose shift count is wrong leaves `data_out` not idle, or empties too early, within the eight host clock edges of the byte being read. The overrun state is visible on the next completed byte. A clear path that fails to reach idle under power-down or mode change is caught on the first clock edge afterwards.

// File: rtl/sw_port_pkg.sv
package sw_port_pkg;
    typedef enum logic [1:0] {F_HUNT, F_BITS, F_STOP} frm_state_t;
    typedef enum logic [1:0] {S_IDLE, S_CLKHI, S_MARK} str_state_t;
    typedef enum logic [1:0] {B_EMPTY, B_READY, B_SHIFT} buf_state_t;
endpackage

// File: rtl/sw_dclk_sync.sv
module sw_dclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/sw_frame_rx.sv
module sw_frame_rx
    import sw_port_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic              dstb,
    output logic              dbit,
    output logic              dlast,
    output logic              fok,
    output logic [WORD_W-1:0] fbyte
);
    localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    frm_state_t        st, nxt;
    logic [CW-1:0]     cnt;
    logic [WORD_W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st <= F_HUNT;
        else if (clr) st <= F_HUNT;
        else          st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            F_HUNT: if (bit_vld && !bit_in)      nxt = F_BITS;
            F_BITS: if (bit_vld && cnt == LAST)  nxt = F_STOP;
            F_STOP: if (bit_vld)                 nxt = F_HUNT;
            default:                             nxt = F_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            sh    <= '0;
            dstb  <= 1'b0;
            dbit  <= 1'b0;
            dlast <= 1'b0;
            fok   <= 1'b0;
            fbyte <= '0;
        end else begin
            dstb  <= 1'b0;
            dlast <= 1'b0;
            fok   <= 1'b0;
            if (clr) begin
                cnt <= '0;
            end else begin
                unique case (st)
                    F_HUNT: cnt <= '0;
                    F_BITS: if (bit_vld) begin
                        dstb  <= 1'b1;
                        dbit  <= bit_in;
                        dlast <= (cnt == LAST);
                        sh    <= {bit_in, sh[WORD_W-1:1]};
                        cnt   <= cnt + 1'b1;
                    end
                    F_STOP: if (bit_vld && bit_in) begin
                        fok   <= 1'b1;
                        fbyte <= sh;
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/sw_stream_out.sv
module sw_stream_out
    import sw_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic half_tick,
    input  logic dstb,
    input  logic dbit,
    input  logic dlast,
    output logic dclk_q,
    output logic data_q,
    output logic dr_n_q
);
    str_state_t st, nxt;
    logic       last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st <= S_IDLE;
        else if (clr) st <= S_IDLE;
        else          st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (dstb) nxt = S_CLKHI;
            S_CLKHI: if (dstb)           nxt = S_CLKHI;
                     else if (half_tick) nxt = last_q ? S_MARK : S_IDLE;
            S_MARK:  if (dstb)           nxt = S_CLKHI;
                     else if (half_tick) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= 1'b1;
            last_q <= 1'b0;
        end else if (clr) begin
            data_q <= 1'b1;
            last_q <= 1'b0;
        end else if (dstb) begin
            data_q <= dbit;
            last_q <= dlast;
        end
    end

    always_comb begin
        dclk_q = (st == S_CLKHI);
        dr_n_q = (st != S_MARK);
    end
endmodule

// File: rtl/sw_byte_buf.sv
module sw_byte_buf
    import sw_port_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fok,
    input  logic [WORD_W-1:0] fbyte,
    input  logic              rise,
    output logic              data_q,
    output logic              dr_n_q,
    output logic              ovr_q
);
    localparam int CW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] FULL = CW'(WORD_W);
    localparam logic [CW-1:0] ONE  = CW'(1);

    buf_state_t        st, nxt;
    logic [WORD_W-1:0] sh;
    logic [CW-1:0]     left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st <= B_EMPTY;
        else if (clr) st <= B_EMPTY;
        else          st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            B_EMPTY: if (fok) nxt = B_READY;
            B_READY: if (fok)       nxt = B_READY;
                     else if (rise) nxt = (left == ONE) ? B_EMPTY : B_SHIFT;
            B_SHIFT: if (fok)       nxt = B_READY;
                     else if (rise && left == ONE) nxt = B_EMPTY;
            default: nxt = B_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh    <= '0;
            left  <= '0;
            ovr_q <= 1'b0;
        end else if (clr) begin
            sh    <= '0;
            left  <= '0;
            ovr_q <= 1'b0;
        end else if (fok) begin
            sh    <= fbyte;
            left  <= FULL;
            if (st != B_EMPTY) ovr_q <= 1'b1;
        end else if (rise && st != B_EMPTY) begin
            sh   <= {1'b0, sh[WORD_W-1:1]};
            left <= left - 1'b1;
        end
    end

    always_comb begin
        data_q = (st == B_EMPTY) ? 1'b1 : sh[0];
        dr_n_q = (st != B_READY);
    end
endmodule

// File: rtl/serial_word_port.sv
module serial_word_port #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwdn,
    input  logic fsk_en,
    input  logic mode_sel,
    input  logic half_tick,
    input  logic bit_vld,
    input  logic bit_in,
    input  logic dclk_in,
    output logic dclk_out,
    output logic dclk_oe,
    output logic data_out,
    output logic dr_n,
    output logic overrun
);
    logic              dstb, dbit, dlast, fok, rise;
    logic [WORD_W-1:0] fbyte;
    logic              s_dclk, s_data, s_dr_n;
    logic              b_data, b_dr_n, b_ovr;
    logic              frm_clr, str_clr, buf_clr;

    assign frm_clr = pwdn | ~fsk_en;
    assign str_clr = pwdn | mode_sel;
    assign buf_clr = pwdn | ~mode_sel;

    sw_frame_rx #(.WORD_W(WORD_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .clr(frm_clr),
        .bit_vld(bit_vld), .bit_in(bit_in),
        .dstb(dstb), .dbit(dbit), .dlast(dlast),
        .fok(fok), .fbyte(fbyte)
    );

    sw_stream_out u_stream (
        .clk(clk), .rst_n(rst_n), .clr(str_clr),
        .half_tick(half_tick), .dstb(dstb), .dbit(dbit), .dlast(dlast),
        .dclk_q(s_dclk), .data_q(s_data), .dr_n_q(s_dr_n)
    );

    sw_dclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(dclk_in), .rise(rise)
    );

    sw_byte_buf #(.WORD_W(WORD_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr),
        .fok(fok), .fbyte(fbyte), .rise(rise),
        .data_q(b_data), .dr_n_q(b_dr_n), .ovr_q(b_ovr)
    );

    assign dclk_oe  = ~mode_sel & ~pwdn;
    assign dclk_out = s_dclk;
    assign data_out = mode_sel ? b_data : s_data;
    assign dr_n     = s_dr_n & b_dr_n;
    assign overrun  = b_ovr;
endmodule

// File: rtl/sw_port_chk.sv
module sw_port_chk (
    input logic clk,
    input logic rst_n,
    input logic pwdn,
    input logic mode_sel,
    input logic dclk_out,
    input logic data_out,
    input logic dr_n,
    input logic overrun
);
    // R9: power-down reaches idle one edge later
    a_r9_pwdn_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pwdn |=> (dr_n && !dclk_out && data_out && !overrun));

    // R7: overrun holds while in host-clock mode and powered
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !pwdn && mode_sel) |=> overrun);

    // R2: no block-driven clock once host-clock mode is settled
    a_r2_no_clk_mode1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && $past(mode_sel)) |-> !dclk_out);

    // R3: word strobe in mode 0 only once the clock pulse has ended
    a_r3_dr_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel && $fell(dr_n)) |-> !dclk_out);
endmodule

bind serial_word_port sw_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwdn(pwdn), .mode_sel(mode_sel),
    .dclk_out(dclk_out), .data_out(data_out), .dr_n(dr_n), .overrun(overrun)
);

// File: tb/serial_word_port_test.sv
module serial_word_port_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic pwdn = 1'b0, fsk_en = 1'b1, mode_sel = 1'b0;
    logic half_tick = 1'b0, bit_vld = 1'b0, bit_in = 1'b1, dclk_in = 1'b0;
    logic dclk_out, dclk_oe, data_out, dr_n, overrun;
    int   n_run = 0, n_fail = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    serial_word_port uut (
        .clk(clk), .rst_n(rst_n), .pwdn(pwdn), .fsk_en(fsk_en),
        .mode_sel(mode_sel), .half_tick(half_tick), .bit_vld(bit_vld),
        .bit_in(bit_in), .dclk_in(dclk_in), .dclk_out(dclk_out),
        .dclk_oe(dclk_oe), .data_out(data_out), .dr_n(dr_n), .overrun(overrun)
    );

    function automatic logic exp_bit(input logic [7:0] b, input int i);
        return b[i];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_vld = 1'b1; bit_in = b;
        @(negedge clk); bit_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk); half_tick = 1'b1;
        @(negedge clk); half_tick = 1'b0;
    endtask

    // mode 0 frame with per-bit checks; live=0 expects no activity (R8)
    task automatic frame_m0(input logic [7:0] b, input bit live);
        send_bit(1'b0);
        check("R2 start no pulse", dclk_out, 0);
        tick(); tick();
        for (int i = 0; i < 8; i++) begin
            send_bit(exp_bit(b, i));
            if (live) begin
                check("R2 pulse high", dclk_out, 1);
                check("R2 data bit", data_out, exp_bit(b, i));
            end else begin
                check("R8 no pulse", dclk_out, 0);
            end
            tick();
            check("R2 pulse end", dclk_out, 0);
            if (live) check("R3 strobe", dr_n, (i == 7) ? 0 : 1);
            else      check("R8 no strobe", dr_n, 1);
            tick();
            check("R3 strobe release", dr_n, 1);
        end
        send_bit(1'b1);
        check("R2 stop no pulse", dclk_out, 0);
        tick(); tick();
    endtask

    task automatic frame_raw(input logic [7:0] b, input logic stopb);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(exp_bit(b, i));
        send_bit(stopb);
    endtask

    task automatic host_edge();
        dclk_in = 1'b1; repeat (5) @(negedge clk);
        dclk_in = 1'b0; repeat (5) @(negedge clk);
    endtask

    task automatic read_m1(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            check("R6 shifted bit", data_out, exp_bit(b, i));
            host_edge();
            if (i == 0) check("R6 strobe release", dr_n, 1);
        end
    endtask

    initial begin
        logic [7:0] v, w;
        void'($urandom(32'd1957));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset dr_n", dr_n, 1);
        check("R1 reset dclk", dclk_out, 0);
        check("R1 reset data", data_out, 1);
        check("R1 reset overrun", overrun, 0);
        check("R1 oe mode0", dclk_oe, 1);

        // mode 0 directed and random
        frame_m0(8'h01, 1'b1);
        frame_m0(8'h80, 1'b1);
        for (int k = 0; k < 6; k++) frame_m0(8'($urandom), 1'b1);
        fsk_en = 1'b0;
        frame_m0(8'hA5, 1'b0);
        fsk_en = 1'b1;

        // mode 1
        mode_sel = 1'b1; @(negedge clk);
        check("R1 oe mode1", dclk_oe, 0);
        for (int k = 0; k < 8; k++) begin
            v = (k == 0) ? 8'hFE : 8'($urandom);
            frame_raw(v, 1'b1);
            check("R5 strobe low", dr_n, 0);
            check("R5 bit0 shown", data_out, exp_bit(v, 0));
            read_m1(v, 8);
            check("R6 empty idle", data_out, 1);
            check("R6 dr high", dr_n, 1);
            check("R7 no overrun", overrun, 0);
        end
        frame_raw(8'h3C, 1'b0);
        check("R4 bad stop dropped", dr_n, 1);
        fsk_en = 1'b0;
        frame_raw(8'h3C, 1'b1);
        check("R8 ignored mode1", dr_n, 1);
        fsk_en = 1'b1;

        // overrun: unread then partially read
        v = 8'h5A; w = 8'hC3;
        frame_raw(v, 1'b1);
        frame_raw(w, 1'b1);
        check("R7 overrun set", overrun, 1);
        check("R7 new strobe", dr_n, 0);
        read_m1(w, 3);
        frame_raw(v, 1'b1);
        check("R7 still set", overrun, 1);
        read_m1(v, 8);
        check("R7 newest byte read", data_out, 1);

        // power down
        pwdn = 1'b1; @(negedge clk); @(negedge clk);
        check("R9 oe off", dclk_oe, 0);
        check("R9 overrun cleared", overrun, 0);
        check("R9 dr idle", dr_n, 1);
        frame_raw(8'h11, 1'b1);
        check("R9 no strobe", dr_n, 1);
        pwdn = 1'b0; mode_sel = 1'b0; @(negedge clk);
        check("R1 oe back", dclk_oe, 1);
        frame_m0(8'h69, 1'b1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule